// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management side of a two-wire PHY management bus. It produces the management clock, `mdc`, from the system clock. It also drives or releases the shared data line through an output value and an output enable that control an external tristate buffer. A host issues one command per transaction: either a register read or a register write. Each command carries a 5-bit PHY address and a 5-bit register address, and a write also carries 16 bits of data. When the transaction ends, the host sees a one-cycle `done` pulse, the read data and an error flag.

Every frame has the same opening. It sends 33 ones, a start pattern, an opcode, the PHY address and the register address. After that opening, a write drives a turnaround pattern and then its data. A read releases the line and checks that the PHY pulls the second turnaround slot low, then shifts in 16 data bits. If the PHY does not pull that slot low, the block clocks 32 more released slots to resynchronise the bus. It then reports an error and returns all-ones data.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted, and after it is released with no command, `mdc` is low, `mdio_oe` is low, and `busy`, `done`, `err` and `rdata` are all zero.
- R2: Every frame starts with 33 MDC periods in which `mdio_oe` is high and `mdio_o` is 1.
- R3: The next four slots carry, in order, 0, 1 and then the opcode. The opcode is 1 then 0 for a read and 0 then 1 for a write. `mdio_oe` stays high through these slots.
- R4: The next ten slots carry `cmd_phy` and then `cmd_reg`, each most significant bit first, with `mdio_oe` high.
- R5: A write continues with 1, then 0, then `cmd_wdata` most significant bit first. All of these slots are driven, so the whole frame is 65 MDC periods long.
- R6: A read releases `mdio_oe` for every slot after the register address. It samples the line on the rising edge of `mdc` in slot 49 (0-based) and the 15 slots after it, most significant bit first. It ends after 65 MDC periods with that word on `rdata` and `err` low.
- R7: If the line is high when sampled in slot 48 of a read, the block clocks 32 further released periods, for 81 in total. It then ends with `err` high and `rdata` equal to 16'hFFFF.
- R8: At the end of every transaction `mdio_oe` returns low and `mdc` stays low until the next command.
- R9: `busy` rises on the clock edge after a command is accepted. It falls on the same edge that raises `done`, and `done` lasts one cycle. A `cmd_valid` seen while `busy` is high is ignored: it changes neither the current frame nor starts a later one.
- R10: `mdc` is high for `DIV_HALF` system clocks and low for `DIV_HALF` system clocks, so one period is 2×`DIV_HALF` system clocks. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R11: A write leaves `rdata` unchanged. `err` is cleared when any new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 16 | Last read result |
| err | output | 1 | Turnaround failure on the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value toward the tristate buffer |
| mdio_oe | output | 1 | Buffer enable; low releases the line |
| mdio_i | input | 1 | Sampled line value |

## Verification
The bench models a PHY that drives the line by MDC slot index and records each driven bit at each MDC rise. A design that is off by one in the preamble or header counters would move every later field by one slot. That shift shows up as a mismatch in the start/opcode and address checks. For the turnaround failure, the bench expects a frame of exactly 81 periods, all-ones data and `err` set. A design that skipped the flush, or kept the partially shifted word, would end early or return a different value. The bench also sends a second command in the middle of a write. A design that latched it would alter the frame or start an extra transaction. A read following a write checks that the write did not touch `rdata`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 33;
  localparam int HDR_LEN   = 4 + 2 * ADDR_W;
  localparam int WTAIL_LEN = 2 + DATA_W;
  localparam int TA_LEN    = 2;
  localparam int FLUSH_LEN = 32;
  localparam int TX_W      = HDR_LEN + WTAIL_LEN;
  localparam int CNT_W     = 6;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_WTAIL,
    ST_RTA,
    ST_RDATA,
    ST_FLUSH
  } mdio_state_e;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap &&  mdc_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              mdio_o,
  output logic              mdio_oe
);
  mdio_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              is_rd_q, is_rd_d;
  logic              ta_bad_q, ta_bad_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    rd_d     = rd_q;
    is_rd_d  = is_rd_q;
    ta_bad_d = ta_bad_q;
    err_d    = err_q;
    done_d   = 1'b0;

    if (st_q == ST_IDLE) begin
      if (cmd_valid) begin
        st_d     = ST_PRE;
        cnt_d    = CNT_W'(PRE_LEN - 1);
        tx_d     = {SOF_BITS, (cmd_read ? OP_READ : OP_WRITE), cmd_phy, cmd_reg,
                    TA_DRIVE, cmd_wdata};
        is_rd_d  = cmd_read;
        ta_bad_d = 1'b0;
        err_d    = 1'b0;
      end
    end else begin
      if (rise_evt) begin
        if (st_q == ST_RTA && last) ta_bad_d = mdio_i;
        if (st_q == ST_RDATA)       rx_d     = {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        cnt_d = cnt_q - 1'b1;
        unique case (st_q)
          ST_PRE: if (last) begin
            st_d  = ST_HDR;
            cnt_d = CNT_W'(HDR_LEN - 1);
          end
          ST_HDR: begin
            tx_d = tx_q << 1;
            if (last) begin
              st_d  = is_rd_q ? ST_RTA : ST_WTAIL;
              cnt_d = is_rd_q ? CNT_W'(TA_LEN - 1) : CNT_W'(WTAIL_LEN - 1);
            end
          end
          ST_WTAIL: begin
            tx_d = tx_q << 1;
            if (last) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end
          ST_RTA: if (last) begin
            st_d  = ta_bad_q ? ST_FLUSH : ST_RDATA;
            cnt_d = ta_bad_q ? CNT_W'(FLUSH_LEN - 1) : CNT_W'(DATA_W - 1);
          end
          ST_RDATA: if (last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            rd_d   = rx_q;
          end
          ST_FLUSH: if (last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
            rd_d   = '1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rd_q     <= '0;
      is_rd_q  <= 1'b0;
      ta_bad_q <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      rd_q     <= rd_d;
      is_rd_q  <= is_rd_d;
      ta_bad_q <= ta_bad_d;
      err_q    <= err_d;
      done_q   <= done_d;
    end
  end

  always_comb begin
    mdio_oe = (st_q == ST_PRE) || (st_q == ST_HDR) || (st_q == ST_WTAIL);
    mdio_o  = (st_q == ST_PRE) ? 1'b1 : (mdio_oe ? tx_q[TX_W-1] : 1'b1);
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign rdata = rd_q;
  assign err   = err_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic rst_sync_n;
  logic rise_evt, fall_evt;
  logic busy_w;

  mdio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (busy_w),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .cmd_valid (cmd_valid),
    .cmd_read  (cmd_read),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .mdio_i    (mdio_i),
    .busy      (busy_w),
    .done      (done),
    .rdata     (rdata),
    .err       (err),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  assign busy = busy_w;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_HALF = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        err,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (mdc) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  a_r10_mdio_stable_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r10_mdc_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == 16'(DIV_HALF)));

  a_r9_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  a_r7_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == 16'hFFFF));
endmodule

bind mdio_master mdio_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .rdata   (rdata),
  .err     (err),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 3;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        ta_ok;
    logic [15:0] rd;
    logic [15:0] exp_rd;
    logic        exp_err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h01, 5'h02, 16'h0000, 1'b1, 16'hA5C3, 16'hA5C3, 1'b0},
    '{1'b1, 5'h1F, 5'h00, 16'h1234, 1'b1, 16'h0000, 16'hA5C3, 1'b0},
    '{1'b0, 5'h0A, 5'h15, 16'h0000, 1'b0, 16'h5555, 16'hFFFF, 1'b1},
    '{1'b0, 5'h10, 5'h1F, 16'h0000, 1'b1, 16'h0001, 16'h0001, 1'b0},
    '{1'b1, 5'h00, 5'h11, 16'hFFFE, 1'b1, 16'h0000, 16'h0001, 1'b0},
    '{1'b0, 5'h15, 5'h0A, 16'h0000, 1'b1, 16'h8000, 16'h8000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_i;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int   slot = 0;
  int   cyc = 0;
  int   last_rise = 0;
  int   rise_period = 0;
  logic cap_o  [0:127];
  logic cap_oe [0:127];
  logic        cur_wr = 1'b1;
  logic        cur_ta_ok = 1'b1;
  logic [15:0] cur_rd = '0;

  mdio_master #(.DIV_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // 250 MHz: 4-unit period
  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  // PHY model: responds by slot index; line pulled up when nobody drives
  always_comb begin
    mdio_i = 1'b1;
    if (mdio_oe) mdio_i = mdio_o;
    else if (!cur_wr) begin
      if (slot == 48) mdio_i = cur_ta_ok ? 1'b0 : 1'b1;
      else if (slot >= 49 && slot <= 64 && cur_ta_ok) mdio_i = cur_rd[64 - slot];
    end
  end

  always @(posedge mdc) begin
    if (slot < 128) begin
      cap_o[slot]  = mdio_o;
      cap_oe[slot] = mdio_oe;
    end
    slot++;
    rise_period = cyc - last_rise;
    last_rise = cyc;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v, input bit inject);
    logic [63:0] a;
    logic [13:0] hdr;
    logic [17:0] tail;
    int wait_n;
    int bad_oe;
    @(negedge clk);
    cur_wr = v.wr; cur_ta_ok = v.ta_ok; cur_rd = v.rd;
    slot = 0;
    cmd_valid = 1'b1; cmd_read = ~v.wr; cmd_phy = v.phy; cmd_reg = v.rg; cmd_wdata = v.wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 busy after accept", {63'd0, busy}, 64'd1);
    if (inject) begin
      repeat (60) @(negedge clk);
      cmd_valid = 1'b1; cmd_read = 1'b1; cmd_phy = 5'h03; cmd_reg = 5'h07; cmd_wdata = 16'h0F0F;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    // R2 preamble
    a = '0;
    for (int k = 0; k < 33; k++) a[k] = cap_o[k] & cap_oe[k];
    chk("R2 preamble", a, {31'd0, {33{1'b1}}});
    hdr = {2'b01, (v.wr ? 2'b01 : 2'b10), v.phy, v.rg};
    a = '0;
    for (int k = 33; k < 37; k++) a[3 - (k - 33)] = cap_o[k];
    chk("R3 start/opcode", a, {60'd0, hdr[13:10]});
    a = '0;
    for (int k = 37; k < 47; k++) a[9 - (k - 37)] = cap_o[k];
    chk("R4 phy/reg", a, {54'd0, hdr[9:0]});
    a = '0;
    for (int k = 33; k < 47; k++) a[k - 33] = cap_oe[k];
    chk("R3 R4 header driven", a, {50'd0, 14'h3FFF});
    if (v.wr) begin
      tail = {2'b10, v.wd};
      a = '0;
      for (int k = 47; k < 65; k++) a[17 - (k - 47)] = cap_o[k] & cap_oe[k];
      chk("R5 write tail", a, {46'd0, tail});
      chk("R5 frame length", 64'(slot), 64'd65);
    end else begin
      bad_oe = 0;
      for (int k = 47; k < slot && k < 128; k++) if (cap_oe[k]) bad_oe++;
      chk("R6 R7 released after address", 64'(bad_oe), 64'd0);
      chk(v.ta_ok ? "R6 frame length" : "R7 flush length", 64'(slot), v.ta_ok ? 64'd65 : 64'd81);
    end
    chk(v.wr ? "R11 rdata kept" : (v.ta_ok ? "R6 rdata" : "R7 rdata"), {48'd0, rdata}, {48'd0, v.exp_rd});
    chk(v.ta_ok ? "R11 R6 err" : "R7 err", {63'd0, err}, {63'd0, v.exp_err});
    chk("R8 released at end", {62'd0, mdio_oe, mdc}, 64'd0);
    @(negedge clk);
    chk("R9 done one cycle", {62'd0, done, busy}, 64'd0);
    if (inject) begin
      repeat (300) @(negedge clk);
      chk("R9 no late transaction", {63'd0, busy}, 64'd0);
      chk("R9 no extra slots", 64'(slot), 64'd65);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {44'd0, mdc, mdio_oe, busy, done, err, rdata[14:0]}, 64'd0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 after release", {43'd0, mdc, mdio_oe, busy, done, err, rdata}, 64'd0);

    for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0);

    chk("R10 mdc period", 64'(rise_period), 64'(2 * HALF));

    run_txn('{1'b1, 5'h05, 5'h06, 16'hC0DE, 1'b1, 16'h0000, 16'h8000, 1'b0}, 1'b1);

    // back-to-back: TA failure followed at once by a good read clears err
    run_txn('{1'b0, 5'h1E, 5'h01, 16'h0000, 1'b0, 16'h0000, 16'hFFFF, 1'b1}, 1'b0);
    run_txn('{1'b0, 5'h01, 5'h1E, 16'h0000, 1'b1, 16'h7FFF, 16'h7FFF, 1'b0}, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule